// File: doc/BRIEF.md
# Recency Stack with Selectable Insertion

This block holds the replacement state of one set in a 16-way set-associative cache. The state is an ordered list of way numbers. Position 0 is the most-recently-used (MRU) end and position 15 is the least-recently-used (LRU) end. A hit strobe moves the named way to the MRU end. A fill strobe evicts the way at the LRU end, which the block reports on `victim_o`. The same fill then places the incoming line in the list according to a two-bit insertion mode.

Three insertion modes are supported. The conventional mode sends the new line to MRU. The LRU-parking mode leaves it at the LRU end, so the line stays the next victim unless a hit reuses it first. The bimodal mode normally parks the line at LRU, but sends it to MRU about once in every 32 fills. That choice is made by an internal 16-bit linear feedback shift register (LFSR). Because victim choice and placement are separate steps, the surrounding cache can resist thrashing by parking fills at LRU. The block keeps no tags and no data, and it does not choose the mode itself.

Top module: `recency_stack`

## Requirements
- R1: After a synchronous active-low reset, position k of the order holds way k for every k: way 0 is at MRU and way 15 is at LRU. The order output packs position k into bits [4k+3:4k].
- R2: The order always holds each of the 16 way numbers exactly once.
- R3: A hit on way w moves w to position 0. Entries that stood above w's old position each move one place toward LRU. Entries below that position are unchanged.
- R4: `victim_o` always shows the way at the LRU position of the order as it stands after any hit in the same cycle has been applied.
- R5: A fill in mode 0 moves the victim to MRU, and every other entry moves one place toward LRU.
- R6: A fill in mode 1, or in mode 3, leaves the order unchanged, so the victim stays at LRU.
- R7: A fill in mode 2 acts as in R5 when the LFSR's low 5 bits are all zero, and as in R6 otherwise.
- R8: The LFSR resets to 0xACE1. On each fill, in any mode, it advances once by a right shift with feedback mask 0xB400, applied when the outgoing bit 0 is 1. Without a fill it holds its value. The R7 decision uses the value held before the advance.
- R9: When a hit and a fill occur in the same cycle, the hit is applied first. The fill then uses the victim and placement taken from the order that results from the hit.
- R10: A cycle with neither strobe leaves the order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_i | input | 1 | Hit strobe for one cycle |
| hit_way_i | input | 4 | Way that was hit |
| fill_i | input | 1 | Fill strobe for one cycle |
| mode_i | input | 2 | Insertion mode: 0 MRU, 1 LRU, 2 bimodal, 3 LRU |
| victim_o | output | 4 | Way evicted by a fill in this cycle |
| order_o | output | 64 | Recency order, position 0 (MRU) in the low nibble |

## Verification
A corrupted entry in the order shows on `order_o` in the cycle after the update that caused it. A lost or duplicated way shows there as a broken permutation, and it also shows on `victim_o` as soon as the corrupted entry reaches the LRU end. A fault in the LFSR step or in its enable has no effect on placement until a bimodal fill occurs. From then on, it moves the MRU inserts away from the fills where the bench model predicts them, so long runs of bimodal fills are compared position by position. The combined hit-and-fill cases are swept in every mode, with the hit aimed at the LRU way and at middle positions.

// File: rtl/rs_pkg.sv
// Package rs_pkg
// Holds the shared encoding of the insertion mode.
// Assumes: the mode is a two-bit field driven by logic outside the block.
package rs_pkg;
    typedef enum logic [1:0] {
        INS_MRU     = 2'b00,
        INS_LRU     = 2'b01,
        INS_BIMODAL = 2'b10,
        INS_PARK    = 2'b11
    } ins_mode_e;
endpackage

// File: rtl/rs_lfsr.sv
// Module rs_lfsr
// Galois LFSR with right shift. It steps once for each cycle in which step_i is high.
// Assumes: SEED is non-zero and TAPS describes a maximal-length polynomial.
module rs_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] st_q;

    // advance the register on each step, or load the seed in reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= SEED;
        else if (step_i)
            st_q <= {1'b0, st_q[W-1:1]} ^ (st_q[0] ? TAPS : '0);
    end

    assign state_o = st_q;
endmodule

// File: rtl/rs_promote.sv
// Module rs_promote
// Combinational move-to-front. The entry equal to way_i goes to position 0, and the
// entries that stood above it each slide one place toward the LRU end.
// Assumes: order_i is a permutation, so way_i occurs exactly once.
module rs_promote #(
    parameter int WAYS = 16,
    parameter int IW   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][IW-1:0] order_i,
    input  logic [IW-1:0]           way_i,
    output logic [WAYS-1:0][IW-1:0] order_o
);
    logic [WAYS-1:0] at_or_below;   // bit i set when the match is at position i or deeper

    // build the suffix OR of position matches
    always_comb begin
        at_or_below[WAYS-1] = (order_i[WAYS-1] == way_i);
        for (int i = WAYS - 2; i >= 0; i--)
            at_or_below[i] = at_or_below[i+1] | (order_i[i] == way_i);
    end

    assign order_o[0] = way_i;

    for (genvar g = 1; g < WAYS; g++) begin : g_slot
        assign order_o[g] = at_or_below[g] ? order_i[g-1] : order_i[g];
    end
endmodule

// File: rtl/recency_stack.sv
// Module recency_stack
// Replacement state for one cache set, kept as a list of way numbers from MRU to LRU.
// A hit promotes its way first. A fill then takes the LRU way as the victim and places
// it according to mode_i.
// Assumes: hit_way_i is valid whenever hit_i is high, and strobes last one cycle.
module recency_stack #(
    parameter int             WAYS          = 16,
    parameter int             IW            = $clog2(WAYS),
    parameter int             LFSR_W        = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED  = 16'hACE1,
    parameter int             THROTTLE_BITS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_i,
    input  logic [IW-1:0]      hit_way_i,
    input  logic               fill_i,
    input  logic [1:0]         mode_i,
    output logic [IW-1:0]      victim_o,
    output logic [WAYS*IW-1:0] order_o
);
    import rs_pkg::*;

    logic [WAYS-1:0][IW-1:0] ord_q;
    logic [WAYS-1:0][IW-1:0] hit_prom;
    logic [WAYS-1:0][IW-1:0] after_hit;
    logic [WAYS-1:0][IW-1:0] fill_prom;
    logic [WAYS-1:0][IW-1:0] ord_d;
    logic [LFSR_W-1:0]       lfsr_q;
    logic                    to_mru;
    ins_mode_e               mode;

    assign mode = ins_mode_e'(mode_i);

    rs_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (fill_i),
        .state_o(lfsr_q)
    );

    rs_promote #(.WAYS(WAYS), .IW(IW)) u_hit_prom (
        .order_i(ord_q),
        .way_i  (hit_way_i),
        .order_o(hit_prom)
    );

    // apply the hit before anything else
    always_comb after_hit = hit_i ? hit_prom : ord_q;

    assign victim_o = after_hit[WAYS-1];

    rs_promote #(.WAYS(WAYS), .IW(IW)) u_fill_prom (
        .order_i(after_hit),
        .way_i  (victim_o),
        .order_o(fill_prom)
    );

    // decide whether this fill is placed at MRU
    always_comb begin
        unique case (mode)
            INS_MRU:     to_mru = 1'b1;
            INS_BIMODAL: to_mru = (lfsr_q[THROTTLE_BITS-1:0] == '0);
            default:     to_mru = 1'b0;
        endcase
    end

    // pick the next order: an MRU fill on top of the hit result
    always_comb ord_d = (fill_i && to_mru) ? fill_prom : after_hit;

    // hold the order register, which resets to the identity permutation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WAYS; k++)
                ord_q[k] <= IW'(k);
        end else begin
            ord_q <= ord_d;
        end
    end

    assign order_o = ord_q;
endmodule

// File: rtl/rs_checker.sv
// Module rs_checker
// Property checks for recency_stack. They are attached by the bind statement at the end of this file.
// Assumes: it sees the top's ports and the internal LFSR state.
module rs_checker #(
    parameter int WAYS   = 16,
    parameter int IW     = 4,
    parameter int LFSR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hit_i,
    input logic [IW-1:0]      hit_way_i,
    input logic               fill_i,
    input logic [1:0]         mode_i,
    input logic [IW-1:0]      victim_o,
    input logic [WAYS*IW-1:0] order_o,
    input logic [LFSR_W-1:0]  lfsr_q
);
    function automatic logic is_perm(input logic [WAYS*IW-1:0] o);
        logic [WAYS-1:0] seen;
        seen = '0;
        for (int k = 0; k < WAYS; k++)
            seen[o[k*IW +: IW]] = 1'b1;
        return &seen;
    endfunction

    // check the permutation on every active cycle
    always @(posedge clk) begin
        if (rst_n) begin
            // R2
            order_perm_chk: assert (is_perm(order_o));
        end
    end

    // R3
    hit_to_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !fill_i) |=> (order_o[IW-1:0] == $past(hit_way_i)));

    // R4
    victim_is_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |-> (victim_o == order_o[WAYS*IW-1 -: IW]));

    // R5
    mru_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && mode_i == 2'b00) |=> (order_o[IW-1:0] == $past(victim_o)));

    // R6
    park_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !hit_i && mode_i[0]) |=> $stable(order_o));

    // R8
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_i |=> $stable(lfsr_q));

    // R8
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i && !fill_i) |=> $stable(order_o));
endmodule

bind recency_stack rs_checker #(.WAYS(WAYS), .IW(IW), .LFSR_W(LFSR_W)) u_rs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit_i),
    .hit_way_i(hit_way_i),
    .fill_i   (fill_i),
    .mode_i   (mode_i),
    .victim_o (victim_o),
    .order_o  (order_o),
    .lfsr_q   (lfsr_q)
);

// File: tb/test_recency_stack.sv
// Bench test_recency_stack
// Drives sweeps of hits, fills and modes, and compares every output against a
// reference list and LFSR that the bench computes from the requirements.
module test_recency_stack;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_i = 1'b0;
    logic [3:0]  hit_way_i = '0;
    logic        fill_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [3:0]  victim_o;
    logic [63:0] order_o;

    int n_tests = 0;
    int n_fail  = 0;
    int mru_inserts = 0;
    bit done = 0;

    int          m_ord [NW];
    logic [15:0] m_lfsr;

    recency_stack i_recency_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit_i),
        .hit_way_i(hit_way_i),
        .fill_i   (fill_i),
        .mode_i   (mode_i),
        .victim_o (victim_o),
        .order_o  (order_o)
    );

    // free-running clock
    always #(CLK_PERIOD / 2) clk = ~clk;

    // move way w to the front of the model list
    function automatic void m_front(int w);
        int p = 0;
        for (int i = 0; i < NW; i++) if (m_ord[i] == w) p = i;
        for (int i = p; i > 0; i--) m_ord[i] = m_ord[i-1];
        m_ord[0] = w;
    endfunction

    function automatic logic [63:0] m_pack();
        logic [63:0] v = '0;
        for (int i = 0; i < NW; i++) v[i*4 +: 4] = 4'(m_ord[i]);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_perm(input string tag);
        logic [15:0] seen = '0;
        for (int i = 0; i < NW; i++) seen[order_o[i*4 +: 4]] = 1'b1;
        chk(tag, 64'(seen), 64'hFFFF);
    endtask

    // one cycle of stimulus with checks of the victim before the edge and of the order after it
    task automatic step(input bit h, input int hw, input bit f, input int m, input string tag);
        bit to_mru;
        @(negedge clk);
        hit_i = h; hit_way_i = 4'(hw); fill_i = f; mode_i = 2'(m);
        if (h) m_front(hw);
        #1;
        chk({tag, " victim (R4)"}, 64'(victim_o), 64'(m_ord[NW-1]));
        if (f) begin
            to_mru = (m == 0) || (m == 2 && m_lfsr[4:0] == 5'd0);
            if (to_mru) begin
                if (m == 2) mru_inserts++;
                m_front(m_ord[NW-1]);
            end
            m_lfsr = {1'b0, m_lfsr[15:1]} ^ (m_lfsr[0] ? 16'hB400 : 16'h0);
        end
        @(posedge clk);
        #1;
        hit_i = 0; fill_i = 0;
        chk(tag, order_o, m_pack());
    endtask

    // watchdog: an expired run counts as a failed check
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) m_ord[i] = i;
        m_lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset order", order_o, m_pack());
        chk("R1 reset victim", 64'(victim_o), 64'd15);
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 0, 0, 0, "R10 idle");
        step(0, 0, 0, 2, "R10 idle bimodal");

        // R3: hit every way from LRU upward, then the current MRU way
        for (int w = 15; w >= 0; w--) step(1, w, 0, 0, "R3 hit sweep");
        step(1, m_ord[0], 0, 1, "R3 hit on MRU");
        for (int w = 0; w < NW; w += 3) step(1, w, 0, 2, "R3 hit mixed");

        // R5: fills in conventional mode
        for (int n = 0; n < 20; n++) step(0, 0, 1, 0, "R5 MRU fill");
        // R6: parking fills in modes 1 and 3
        for (int n = 0; n < 8; n++) step(0, 0, 1, 1, "R6 LRU fill");
        for (int n = 0; n < 8; n++) step(0, 0, 1, 3, "R6 mode3 fill");

        // R7 and R8: long bimodal run with occasional hits
        for (int n = 0; n < 1500; n++) begin
            if (n % 7 == 3) step(1, (n * 5) % NW, 0, 2, "R8 hit without fill");
            step(0, 0, 1, 2, "R7 R8 bimodal fill");
        end
        chk("R7 some bimodal MRU inserts", 64'(mru_inserts > 0), 64'd1);

        // R9: hit and fill together, aimed at the LRU way and at middle positions, in every mode
        for (int m = 0; m < 4; m++) begin
            for (int p = 15; p >= 0; p -= 5) step(1, m_ord[p], 1, m, "R9 hit+fill");
        end

        // R2: random traffic with a permutation check after each cycle
        for (int n = 0; n < 3000; n++) begin
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), "R2 R9 random");
            chk_perm("R2 permutation");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule